// File: doc/BRIEF.md
# Instruction Pair Fusion Detector

This block sits behind an instruction decoder and looks at two neighbouring, already decoded instructions at once: a head instruction and the one that follows it. Each comes in as an operation code, three register indices, a signed immediate and a length flag (2 or 4 bytes). When the pair matches one of a fixed set of idioms and the register aliasing rules for that idiom hold, the block replaces the pair with a single fused internal operation. The fused operation carries its own register operands, a combined immediate where the idiom has one, and a length equal to the sum of the two instruction lengths. When there is no match, the head instruction comes out as it went in.

The idioms are:
- a high-half multiply followed by the low-half multiply on the same sources;
- a divide followed by the matching remainder;
- an upper-immediate load followed by a 32-bit add-immediate, or by a jump-and-link-register through the return-address register;
- a PC-relative upper immediate followed by the same jump, or by an add-immediate;
- a subtract followed by an unsigned compare of the same operands.

A version input turns on the stricter rules. Under those rules, two extra idioms are enabled, and immediate combines that would overflow a signed 32-bit value suppress fusion instead of wrapping. The decision logic is combinational. Its result is captured into output registers one clock after a valid input.

Top module: `fuse_pair_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, `out_valid` becomes 0 and all output fields become 0.
- R2: `out_valid` at each rising edge takes the value `in_valid` had just before it. When `in_valid` is 1, the output fields take the result for the pair presented. When `in_valid` is 0, the output fields hold their previous values.
- R3: Multiply pair. A head of MULH (code 9), MULHU (10) or MULHSU (11) followed by MUL (8) fuses into code 16, 17 or 18 respectively. This requires that the head rd differs from the head rs1 and from the head rs2, that the two instructions have equal rs1 and equal rs2, and that the two rd differ. Outputs: rd = head rd, rd2 = next rd, rs1/rs2 = shared sources, imm = 0. This applies in every version.
- R4: Divide pair. DIV (12) followed by REM (14) fuses into code 19, and DIVU (13) followed by REMU (15) fuses into code 20. The register conditions and output mapping are the same as in R3, with rd = quotient destination and rd2 = remainder destination.
- R5: Load-immediate pair. LUI (1) followed by ADDIW (4) fuses into code 21 when the ADDIW rd and rs1 both equal the LUI rd. Outputs: rd = that register, imm = wrapping 32-bit sum of the two immediates, and rd2/rs1/rs2 = 0. The LUI immediate is supplied already shifted and sign-extended.
- R6: Jump pair. LUI (1) or AUIPC (2) followed by JALR (5) fuses into code 22 (absolute) or 23 (PC-relative). This requires that the JALR rs1 equals the head rd and the JALR rd equals register 1. When the version is 2 or more, the JALR rs1 must also be register 1. Outputs: rd = 1, imm = sum of the immediates, and rd2/rs1/rs2 = 0.
- R7: For AUIPC+JALR with version 2 or more, a signed 32-bit overflow in the immediate sum blocks fusion. With version below 2, and always for LUI+JALR, the sum wraps.
- R8: With version 2 or more, AUIPC (2) followed by ADDI (3) fuses into code 21. This requires that the ADDI rd and rs1 equal the AUIPC rd, that `pc` fits in signed 32 bits, and that neither step of the addition overflows signed 32 bits. The steps are `pc` plus the AUIPC immediate, then that sum plus the ADDI immediate. Outputs: rd = that register, imm = the final sum. With version below 2 this pair never fuses.
- R9: With version 2 or more, SUB r0,r1,r2 (6) followed by SLTU r3,r1,r2 (7) fuses into code 24 when r0 differs from r1 and from r2. Outputs: rd = r0, rd2 = r3, rs1 = r1, rs2 = r2, imm = 0. With version below 2 this pair never fuses.
- R10: A length flag of 1 means 4 bytes and 0 means 2 bytes. `out_len` is the head length plus the next length in bytes for a fused result, and the head length otherwise.
- R11: With `n_valid` = 0, the head passes through unchanged whatever the next-instruction fields hold, and no error is raised.
- R12: Any pair without a match passes through. In that case out_op, rd, rs1, rs2 and imm equal the head fields, and rd2 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Pair presented this cycle |
| version | input | VER_W | Rule version; strict rules from STRICT_VER up |
| pc | input | PC_W | Address of the head instruction |
| h_op | input | OP_W | Head operation code |
| h_rd | input | REG_W | Head destination |
| h_rs1 | input | REG_W | Head source 1 |
| h_rs2 | input | REG_W | Head source 2 |
| h_imm | input | IMM_W | Head immediate, sign-extended |
| h_len4 | input | 1 | Head is 4 bytes (else 2) |
| n_valid | input | 1 | Next instruction is available and valid |
| n_op | input | OP_W | Next operation code |
| n_rd | input | REG_W | Next destination |
| n_rs1 | input | REG_W | Next source 1 |
| n_rs2 | input | REG_W | Next source 2 |
| n_imm | input | IMM_W | Next immediate, sign-extended |
| n_len4 | input | 1 | Next is 4 bytes (else 2) |
| out_valid | output | 1 | Result valid |
| out_op | output | OP_W | Fused or passed-through operation code |
| out_rd | output | REG_W | First destination |
| out_rd2 | output | REG_W | Second destination (fused pairs) |
| out_rs1 | output | REG_W | Source 1 |
| out_rs2 | output | REG_W | Source 2 |
| out_imm | output | IMM_W | Result immediate |
| out_len | output | LEN_W | Covered length in bytes |

## Verification
Every result is due exactly one rising edge after the pair is presented with `in_valid` high. The bench drives each pair on a falling edge and compares all outputs on the next falling edge, half a period after the capturing edge, so each check sees only the pair it drove. It also makes one idle cycle, to show that the fields hold and `out_valid` drops in that same one-edge window. The expected results, including the overflow decisions, come from 64-bit integer arithmetic in the bench rather than from sign-bit tests.

// File: rtl/fuse_pkg.sv
package fuse_pkg;

    localparam int REG_W  = 5;
    localparam int IMM_W  = 32;
    localparam int OP_W   = 5;
    localparam int LEN_W  = 4;
    localparam int RA_IDX = 1;

    typedef enum logic [OP_W-1:0] {
        OP_OTHER     = 5'd0,
        OP_LUI       = 5'd1,
        OP_AUIPC     = 5'd2,
        OP_ADDI      = 5'd3,
        OP_ADDIW     = 5'd4,
        OP_JALR      = 5'd5,
        OP_SUB       = 5'd6,
        OP_SLTU      = 5'd7,
        OP_MUL       = 5'd8,
        OP_MULH      = 5'd9,
        OP_MULHU     = 5'd10,
        OP_MULHSU    = 5'd11,
        OP_DIV       = 5'd12,
        OP_DIVU      = 5'd13,
        OP_REM       = 5'd14,
        OP_REMU      = 5'd15,
        FU_MULW_S    = 5'd16,
        FU_MULW_U    = 5'd17,
        FU_MULW_SU   = 5'd18,
        FU_DIVW_S    = 5'd19,
        FU_DIVW_U    = 5'd20,
        FU_LDIMM     = 5'd21,
        FU_JMP_ABS   = 5'd22,
        FU_JMP_REL   = 5'd23,
        FU_SUB_BORROW = 5'd24
    } op_e;

    typedef struct packed {
        op_e                     op;
        logic [REG_W-1:0]        rd;
        logic [REG_W-1:0]        rs1;
        logic [REG_W-1:0]        rs2;
        logic signed [IMM_W-1:0] imm;
        logic                    len4;
    } insn_t;

    typedef struct packed {
        op_e                     op;
        logic [REG_W-1:0]        rd;
        logic [REG_W-1:0]        rd2;
        logic [REG_W-1:0]        rs1;
        logic [REG_W-1:0]        rs2;
        logic signed [IMM_W-1:0] imm;
    } res_t;

    typedef struct packed {
        logic signed [IMM_W-1:0] sum;
        logic                    ovf;
    } sadd_t;

    function automatic sadd_t sadd(input logic signed [IMM_W-1:0] a,
                                   input logic signed [IMM_W-1:0] b);
        sadd_t r;
        r.sum = a + b;
        r.ovf = (a[IMM_W-1] == b[IMM_W-1]) && (r.sum[IMM_W-1] != a[IMM_W-1]);
        return r;
    endfunction

    function automatic logic [LEN_W-1:0] len_bytes(input logic len4);
        return len4 ? LEN_W'(4) : LEN_W'(2);
    endfunction

    function automatic logic is_fused(input op_e o);
        return o >= FU_MULW_S;
    endfunction

    function automatic logic is_wide_arith(input op_e o);
        return (o >= FU_MULW_S) && (o <= FU_DIVW_U);
    endfunction

endpackage

// File: rtl/fuse_arith_rules.sv
module fuse_arith_rules
    import fuse_pkg::*;
(
    input  insn_t h,
    input  insn_t n,
    input  logic  strict,
    output logic  hit,
    output res_t  res
);

    logic srcs_shared;
    logic head_rd_free;
    logic dests_apart;
    logic pair_regs_ok;

    assign srcs_shared  = (n.rs1 == h.rs1) && (n.rs2 == h.rs2);
    assign head_rd_free = (h.rd != h.rs1) && (h.rd != h.rs2);
    assign dests_apart  = (n.rd != h.rd);
    assign pair_regs_ok = srcs_shared && head_rd_free && dests_apart;

    always_comb begin
        hit     = 1'b0;
        res     = '0;
        res.op  = OP_OTHER;
        res.rd  = h.rd;
        res.rd2 = n.rd;
        res.rs1 = h.rs1;
        res.rs2 = h.rs2;
        unique case (h.op)
            OP_MULH: if (n.op == OP_MUL && pair_regs_ok) begin
                hit    = 1'b1;
                res.op = FU_MULW_S;
            end
            OP_MULHU: if (n.op == OP_MUL && pair_regs_ok) begin
                hit    = 1'b1;
                res.op = FU_MULW_U;
            end
            OP_MULHSU: if (n.op == OP_MUL && pair_regs_ok) begin
                hit    = 1'b1;
                res.op = FU_MULW_SU;
            end
            OP_DIV: if (n.op == OP_REM && pair_regs_ok) begin
                hit    = 1'b1;
                res.op = FU_DIVW_S;
            end
            OP_DIVU: if (n.op == OP_REMU && pair_regs_ok) begin
                hit    = 1'b1;
                res.op = FU_DIVW_U;
            end
            OP_SUB: if (strict && n.op == OP_SLTU && srcs_shared && head_rd_free) begin
                hit    = 1'b1;
                res.op = FU_SUB_BORROW;
            end
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/fuse_imm_rules.sv
module fuse_imm_rules
    import fuse_pkg::*;
#(
    parameter int PC_W = 64
) (
    input  insn_t             h,
    input  insn_t             n,
    input  logic              strict,
    input  logic [PC_W-1:0]   pc,
    output logic              hit,
    output res_t              res
);

    logic pc_fits;
    logic signed [IMM_W-1:0] pc_lo;

    generate
        if (PC_W > IMM_W) begin : g_wide_pc
            logic [PC_W-IMM_W:0] pc_top;
            assign pc_top  = pc[PC_W-1:IMM_W-1];
            assign pc_fits = (&pc_top) || (~|pc_top);
            assign pc_lo   = pc[IMM_W-1:0];
        end else begin : g_narrow_pc
            assign pc_fits = 1'b1;
            assign pc_lo   = IMM_W'(signed'(pc));
        end
    endgenerate

    sadd_t s_pair;
    sadd_t s_pc;
    sadd_t s_all;

    assign s_pair = sadd(h.imm, n.imm);
    assign s_pc   = sadd(pc_lo, h.imm);
    assign s_all  = sadd(s_pc.sum, n.imm);

    logic link_ok;
    logic addiw_ok;
    logic addi_ok;

    assign link_ok  = (n.op == OP_JALR) && (n.rs1 == h.rd) && (n.rd == REG_W'(RA_IDX))
                    && (!strict || n.rs1 == REG_W'(RA_IDX));
    assign addiw_ok = (n.op == OP_ADDIW) && (n.rs1 == h.rd) && (n.rd == h.rd);
    assign addi_ok  = strict && (n.op == OP_ADDI) && (n.rs1 == h.rd) && (n.rd == h.rd)
                    && pc_fits && !s_pc.ovf && !s_all.ovf;

    always_comb begin
        hit     = 1'b0;
        res     = '0;
        res.op  = OP_OTHER;
        unique case (h.op)
            OP_LUI: begin
                if (addiw_ok) begin
                    hit     = 1'b1;
                    res.op  = FU_LDIMM;
                    res.rd  = h.rd;
                    res.imm = s_pair.sum;
                end else if (link_ok) begin
                    hit     = 1'b1;
                    res.op  = FU_JMP_ABS;
                    res.rd  = REG_W'(RA_IDX);
                    res.imm = s_pair.sum;
                end
            end
            OP_AUIPC: begin
                if (link_ok && !(strict && s_pair.ovf)) begin
                    hit     = 1'b1;
                    res.op  = FU_JMP_REL;
                    res.rd  = REG_W'(RA_IDX);
                    res.imm = s_pair.sum;
                end else if (addi_ok) begin
                    hit     = 1'b1;
                    res.op  = FU_LDIMM;
                    res.rd  = h.rd;
                    res.imm = s_all.sum;
                end
            end
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/fuse_pair_top.sv
module fuse_pair_top
    import fuse_pkg::*;
#(
    parameter int PC_W       = 64,
    parameter int VER_W      = 2,
    parameter int STRICT_VER = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [VER_W-1:0]    version,
    input  logic [PC_W-1:0]     pc,
    input  logic [OP_W-1:0]     h_op,
    input  logic [REG_W-1:0]    h_rd,
    input  logic [REG_W-1:0]    h_rs1,
    input  logic [REG_W-1:0]    h_rs2,
    input  logic [IMM_W-1:0]    h_imm,
    input  logic                h_len4,
    input  logic                n_valid,
    input  logic [OP_W-1:0]     n_op,
    input  logic [REG_W-1:0]    n_rd,
    input  logic [REG_W-1:0]    n_rs1,
    input  logic [REG_W-1:0]    n_rs2,
    input  logic [IMM_W-1:0]    n_imm,
    input  logic                n_len4,
    output logic                out_valid,
    output logic [OP_W-1:0]     out_op,
    output logic [REG_W-1:0]    out_rd,
    output logic [REG_W-1:0]    out_rd2,
    output logic [REG_W-1:0]    out_rs1,
    output logic [REG_W-1:0]    out_rs2,
    output logic [IMM_W-1:0]    out_imm,
    output logic [LEN_W-1:0]    out_len
);

    insn_t head;
    insn_t nxt;
    logic  strict;

    assign head   = '{op: op_e'(h_op), rd: h_rd, rs1: h_rs1, rs2: h_rs2, imm: h_imm, len4: h_len4};
    assign nxt    = '{op: op_e'(n_op), rd: n_rd, rs1: n_rs1, rs2: n_rs2, imm: n_imm, len4: n_len4};
    assign strict = (version >= VER_W'(STRICT_VER));

    logic a_hit;
    logic i_hit;
    res_t a_res;
    res_t i_res;

    fuse_arith_rules u_arith (
        .h      (head),
        .n      (nxt),
        .strict (strict),
        .hit    (a_hit),
        .res    (a_res)
    );

    fuse_imm_rules #(.PC_W(PC_W)) u_imm (
        .h      (head),
        .n      (nxt),
        .strict (strict),
        .pc     (pc),
        .hit    (i_hit),
        .res    (i_res)
    );

    res_t             pick;
    logic [LEN_W-1:0] pick_len;

    always_comb begin
        pick     = '{op: head.op, rd: head.rd, rd2: '0, rs1: head.rs1, rs2: head.rs2, imm: head.imm};
        pick_len = len_bytes(head.len4);
        if (n_valid && a_hit) begin
            pick     = a_res;
            pick_len = len_bytes(head.len4) + len_bytes(nxt.len4);
        end else if (n_valid && i_hit) begin
            pick     = i_res;
            pick_len = len_bytes(head.len4) + len_bytes(nxt.len4);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_op    <= '0;
            out_rd    <= '0;
            out_rd2   <= '0;
            out_rs1   <= '0;
            out_rs2   <= '0;
            out_imm   <= '0;
            out_len   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_op  <= pick.op;
                out_rd  <= pick.rd;
                out_rd2 <= pick.rd2;
                out_rs1 <= pick.rs1;
                out_rs2 <= pick.rs2;
                out_imm <= pick.imm;
                out_len <= pick_len;
            end
        end
    end

    // R2: valid follows the input one edge later; fields hold when idle
    p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_idle_follow_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_op) && $stable(out_imm) && $stable(out_len)));

    // R10: fused results span two instructions, pass-through spans one
    p_fused_len_r10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && is_fused(op_e'(out_op))) |-> (out_len >= 4 && out_len <= 8 && !out_len[0]));
    p_pass_len_r12: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !is_fused(op_e'(out_op))) |-> (out_len == 2 || out_len == 4));

    // R3 and R4: wide results never alias their destinations onto sources
    p_wide_alias_r3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && is_wide_arith(op_e'(out_op)))
            |-> (out_rd != out_rs1 && out_rd != out_rs2 && out_rd != out_rd2));

    // R9: borrow form keeps the difference apart from its operands
    p_borrow_alias_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_op == OP_W'(FU_SUB_BORROW))
            |-> (out_rd != out_rs1 && out_rd != out_rs2));

    // R6: both jump forms link through the return-address register
    p_jump_link_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (out_op == OP_W'(FU_JMP_ABS) || out_op == OP_W'(FU_JMP_REL)))
            |-> (out_rd == REG_W'(RA_IDX) && out_rd2 == '0));

endmodule

// File: tb/fuse_pair_top_test.sv
module fuse_pair_top_test;
    import fuse_pkg::*;

    localparam int PC_W = 64;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                rst;
    logic                in_valid;
    logic [1:0]          version;
    logic [PC_W-1:0]     pc;
    logic [OP_W-1:0]     h_op, n_op;
    logic [REG_W-1:0]    h_rd, h_rs1, h_rs2, n_rd, n_rs1, n_rs2;
    logic [IMM_W-1:0]    h_imm, n_imm;
    logic                h_len4, n_len4, n_valid;
    logic                out_valid;
    logic [OP_W-1:0]     out_op;
    logic [REG_W-1:0]    out_rd, out_rd2, out_rs1, out_rs2;
    logic [IMM_W-1:0]    out_imm;
    logic [LEN_W-1:0]    out_len;

    fuse_pair_top #(.PC_W(PC_W), .VER_W(2), .STRICT_VER(2)) uut (
        .clk, .rst, .in_valid, .version, .pc,
        .h_op, .h_rd, .h_rs1, .h_rs2, .h_imm, .h_len4,
        .n_valid, .n_op, .n_rd, .n_rs1, .n_rs2, .n_imm, .n_len4,
        .out_valid, .out_op, .out_rd, .out_rd2, .out_rs1, .out_rs2, .out_imm, .out_len
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired before the sweeps ended");
            summary();
            $finish;
        end
    end

    function automatic logic ovf32(input longint s);
        return (s > 64'sd2147483647) || (s < -64'sd2147483648);
    endfunction

    // Reference model written from the requirement text
    function automatic void model(input insn_t h, input insn_t n, input logic nv,
                                  input logic [1:0] ver, input logic [PC_W-1:0] p,
                                  output res_t r, output logic [LEN_W-1:0] len,
                                  output string tag);
        bit fz = 0;
        bit st = (ver >= 2);
        longint hi = longint'(h.imm);
        longint ni = longint'(n.imm);
        longint pl = longint'(signed'(p));
        bit regs = (h.rd != h.rs1) && (h.rd != h.rs2) && (n.rs1 == h.rs1)
                   && (n.rs2 == h.rs2) && (n.rd != h.rd);
        r   = '{op: h.op, rd: h.rd, rd2: 5'd0, rs1: h.rs1, rs2: h.rs2, imm: h.imm};
        tag = nv ? "R12" : "R11";
        if (nv) begin
            if (n.op == OP_MUL && regs && (h.op == OP_MULH || h.op == OP_MULHU || h.op == OP_MULHSU)) begin
                fz = 1; tag = "R3 R10";
                r = '{op: (h.op == OP_MULH) ? FU_MULW_S : (h.op == OP_MULHU) ? FU_MULW_U : FU_MULW_SU,
                      rd: h.rd, rd2: n.rd, rs1: h.rs1, rs2: h.rs2, imm: '0};
            end else if (regs && ((h.op == OP_DIV && n.op == OP_REM) || (h.op == OP_DIVU && n.op == OP_REMU))) begin
                fz = 1; tag = "R4 R10";
                r = '{op: (h.op == OP_DIV) ? FU_DIVW_S : FU_DIVW_U,
                      rd: h.rd, rd2: n.rd, rs1: h.rs1, rs2: h.rs2, imm: '0};
            end else if (st && h.op == OP_SUB && n.op == OP_SLTU && n.rs1 == h.rs1 && n.rs2 == h.rs2
                         && h.rd != h.rs1 && h.rd != h.rs2) begin
                fz = 1; tag = "R9 R10";
                r = '{op: FU_SUB_BORROW, rd: h.rd, rd2: n.rd, rs1: h.rs1, rs2: h.rs2, imm: '0};
            end else if (h.op == OP_LUI && n.op == OP_ADDIW && n.rs1 == h.rd && n.rd == h.rd) begin
                fz = 1; tag = "R5 R10";
                r = '{op: FU_LDIMM, rd: h.rd, rd2: '0, rs1: '0, rs2: '0, imm: IMM_W'(hi + ni)};
            end else if ((h.op == OP_LUI || h.op == OP_AUIPC) && n.op == OP_JALR && n.rs1 == h.rd
                         && n.rd == 5'd1 && (!st || n.rs1 == 5'd1)
                         && !(st && h.op == OP_AUIPC && ovf32(hi + ni))) begin
                fz = 1; tag = (h.op == OP_AUIPC) ? "R7 R6 R10" : "R6 R10";
                r = '{op: (h.op == OP_LUI) ? FU_JMP_ABS : FU_JMP_REL, rd: 5'd1, rd2: '0,
                      rs1: '0, rs2: '0, imm: IMM_W'(hi + ni)};
            end else if (st && h.op == OP_AUIPC && n.op == OP_ADDI && n.rs1 == h.rd && n.rd == h.rd
                         && !ovf32(pl) && !ovf32(pl + hi) && !ovf32(pl + hi + ni)) begin
                fz = 1; tag = "R8 R10";
                r = '{op: FU_LDIMM, rd: h.rd, rd2: '0, rs1: '0, rs2: '0, imm: IMM_W'(pl + hi + ni)};
            end else if (h.op == OP_AUIPC && n.op == OP_JALR) begin
                tag = "R7";
            end else if (h.op == OP_AUIPC && n.op == OP_ADDI) begin
                tag = "R8";
            end
        end
        len = (h.len4 ? 4'd4 : 4'd2) + (fz ? (n.len4 ? 4'd4 : 4'd2) : 4'd0);
    endfunction

    task automatic compare(input res_t e, input logic [LEN_W-1:0] el, input logic ev, input string tag);
        n_tests++;
        if (out_valid !== ev || out_op !== OP_W'(e.op) || out_rd !== e.rd || out_rd2 !== e.rd2
            || out_rs1 !== e.rs1 || out_rs2 !== e.rs2 || out_imm !== e.imm || out_len !== el) begin
            n_fail++;
            $display("FAIL %s: got v=%0d op=%0d rd=%0d rd2=%0d rs1=%0d rs2=%0d imm=%h len=%0d, expected v=%0d op=%0d rd=%0d rd2=%0d rs1=%0d rs2=%0d imm=%h len=%0d",
                     tag, out_valid, out_op, out_rd, out_rd2, out_rs1, out_rs2, out_imm, out_len,
                     ev, e.op, e.rd, e.rd2, e.rs1, e.rs2, e.imm, el);
        end
    endtask

    res_t             last_r;
    logic [LEN_W-1:0] last_len;

    // Drive at a falling edge, result captured at the next rising edge, checked at the falling edge after
    task automatic run_pair(input insn_t h, input insn_t n, input logic nv,
                            input logic [1:0] ver, input logic [PC_W-1:0] p);
        res_t r; logic [LEN_W-1:0] len; string tag;
        in_valid = 1; version = ver; pc = p; n_valid = nv;
        h_op = h.op; h_rd = h.rd; h_rs1 = h.rs1; h_rs2 = h.rs2; h_imm = h.imm; h_len4 = h.len4;
        n_op = n.op; n_rd = n.rd; n_rs1 = n.rs1; n_rs2 = n.rs2; n_imm = n.imm; n_len4 = n.len4;
        model(h, n, nv, ver, p, r, len, tag);
        @(posedge clk);
        @(negedge clk);
        compare(r, len, 1'b1, tag);
        last_r = r; last_len = len;
    endtask

    op_e ar_heads [6] = '{OP_MULH, OP_MULHU, OP_MULHSU, OP_DIV, OP_DIVU, OP_SUB};
    op_e ar_nexts [4] = '{OP_MUL, OP_REM, OP_REMU, OP_SLTU};
    op_e im_heads [2] = '{OP_LUI, OP_AUIPC};
    op_e im_nexts [3] = '{OP_ADDIW, OP_JALR, OP_ADDI};
    logic [31:0] hi_set [6] = '{32'h0, 32'h1, 32'hffff_ffff, 32'h7fff_f000, 32'h8000_0000, 32'h0000_07ff};
    logic [31:0] ni_set [5] = '{32'h0, 32'h5, 32'hffff_fffc, 32'h0000_07ff, 32'hffff_f800};
    logic [63:0] pc_set [4] = '{64'h1000, 64'h7fff_fffe, 64'h1_0000_0000, 64'hffff_ffff_8000_0000};

    initial begin
        insn_t h, n;
        res_t zero_r;
        rst = 1; in_valid = 0; version = 0; pc = 0; n_valid = 0;
        h_op = 0; h_rd = 0; h_rs1 = 0; h_rs2 = 0; h_imm = 0; h_len4 = 0;
        n_op = 0; n_rd = 0; n_rs1 = 0; n_rs2 = 0; n_imm = 0; n_len4 = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset clears everything
        zero_r = '{op: OP_OTHER, rd: '0, rd2: '0, rs1: '0, rs2: '0, imm: '0};
        compare(zero_r, 4'd0, 1'b0, "R1");
        rst = 0;

        // R3 R4 R9: arithmetic pairs over all register aliasings in {0,1,2}
        for (int ver = 1; ver <= 2; ver++)
            for (int a = 0; a < 6; a++)
                for (int b = 0; b < 4; b++)
                    for (int k = 0; k < 729; k++) begin
                        h = '{op: ar_heads[a], rd: 5'(k % 3), rs1: 5'((k / 3) % 3), rs2: 5'((k / 9) % 3),
                              imm: 32'(k * 7), len4: k[0]};
                        n = '{op: ar_nexts[b], rd: 5'((k / 27) % 3), rs1: 5'((k / 81) % 3),
                              rs2: 5'((k / 243) % 3), imm: 32'(k), len4: k[1]};
                        run_pair(h, n, 1'b1, 2'(ver), 64'h2000);
                    end

        // R5 R6 R7 R8: immediate pairs over aliasing, immediates, addresses and versions
        for (int ver = 1; ver <= 2; ver++)
            for (int a = 0; a < 2; a++)
                for (int b = 0; b < 3; b++)
                    for (int g = 0; g < 27; g++)
                        for (int x = 0; x < 6; x++)
                            for (int y = 0; y < 5; y++)
                                for (int q = 0; q < 4; q++) begin
                                    h = '{op: im_heads[a], rd: 5'(g % 3), rs1: 5'd3, rs2: 5'd4,
                                          imm: hi_set[x], len4: y[0]};
                                    n = '{op: im_nexts[b], rd: 5'((g / 3) % 3), rs1: 5'((g / 9) % 3),
                                          rs2: 5'd0, imm: ni_set[y], len4: q[0]};
                                    run_pair(h, n, 1'b1, 2'(ver), pc_set[q]);
                                end

        // R11: fusable pairs with the second instruction unavailable
        h = '{op: OP_MULH, rd: 5'd3, rs1: 5'd1, rs2: 5'd2, imm: 32'h55, len4: 1'b1};
        n = '{op: OP_MUL,  rd: 5'd4, rs1: 5'd1, rs2: 5'd2, imm: 32'h0, len4: 1'b1};
        run_pair(h, n, 1'b0, 2'd2, 64'h0);
        h = '{op: OP_LUI, rd: 5'd1, rs1: 5'd0, rs2: 5'd0, imm: 32'h1000, len4: 1'b0};
        n = '{op: OP_JALR, rd: 5'd1, rs1: 5'd1, rs2: 5'd0, imm: 32'h8, len4: 1'b1};
        run_pair(h, n, 1'b0, 2'd2, 64'h0);
        h = '{op: OP_SUB, rd: 5'd3, rs1: 5'd1, rs2: 5'd2, imm: 32'h0, len4: 1'b1};
        n = '{op: OP_SLTU, rd: 5'd4, rs1: 5'd1, rs2: 5'd2, imm: 32'h0, len4: 1'b0};
        run_pair(h, n, 1'b0, 2'd3, 64'h0);

        // R12: every head code with a non-matching follower passes through
        for (int c = 0; c < 16; c++) begin
            h = '{op: op_e'(c), rd: 5'd5, rs1: 5'd6, rs2: 5'd7, imm: 32'(c * 1000 - 3), len4: c[0]};
            n = '{op: OP_OTHER, rd: 5'd5, rs1: 5'd6, rs2: 5'd7, imm: 32'h9, len4: 1'b1};
            run_pair(h, n, 1'b1, 2'd2, 64'h10);
        end

        // R2: idle cycle drops valid and holds the fields while inputs change
        h_op = OP_W'(OP_MULH); h_rd = 5'd9; h_imm = 32'hdead; in_valid = 0;
        @(posedge clk);
        @(negedge clk);
        compare(last_r, last_len, 1'b0, "R2");

        done = 1;
        summary();
        $finish;
    end

endmodule